// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Core

This block is a small processor core that completes one instruction in every clock cycle. On each rising edge it commits the work of the instruction addressed by the program counter. That instruction is read from an internal instruction array. It is decoded from its top six bits, its operands are taken from a 32-entry register file and it runs through the ALU. A load reads the internal data array. The result is written back and the next program counter is chosen, all in the same cycle. Register reads, memory reads and every piece of decode are combinational. Only the program counter, the registers and the data array hold state.

Both memory arrays are loaded through a word-wide preload port while the core is held in reset. Three debug outputs let a model-based bench follow execution instruction by instruction: the program counter, the fetched instruction and the write-back port. The write-back port reports the enable, the destination index and the data.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 after that edge and every register reads as zero. Register and data-array writes by instructions are suppressed during reset.
- R2: Every instruction other than a taken branch or a jump advances the program counter by 4. Instruction and data words are selected by address bits [IAW+1:2] and [DAW+1:2], so addresses wrap modulo the array depth.
- R3: Opcodes 0x00, 0x01, 0x02 and 0x03 compute rs+rt, rs-rt, rs AND rt and rs OR rt, and write the result to rd. The fields are rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Opcode 0x08 adds the sign-extended 16-bit immediate [15:0] to rs and writes the sum to rt.
- R5: Register 0 always reads as zero. A write addressed to it is dropped, and the write-back enable stays low for it.
- R6: Opcode 0x2B stores rt to the data word at rs + sign-extended immediate. Opcode 0x23 loads the word at that same address into rt.
- R7: Opcode 0x04 compares rs with rt by subtraction. When they are equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R8: Opcode 0x3F sets the program counter to PC+4 bits [31:28], followed by field [25:0], followed by two zero bits.
- R9: Any other opcode writes neither a register nor memory, and only advances the program counter.
- R10: Stores, branches and jumps never raise the write-back enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Preload write strobe |
| prog_to_dmem | input | 1 | Preload target: 1 selects the data array, 0 the instruction array |
| prog_addr | input | PAW (6) | Preload word index |
| prog_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction being executed |
| dbg_wb_we | output | 1 | Register write occurs at the next edge |
| dbg_wb_idx | output | 5 | Destination register index |
| dbg_wb_data | output | 32 | Value written back |

## Verification
The properties assume that `rst` is high from time zero and that both arrays are fully written before reset is released, so no fetched opcode is ever unknown. They also assume the preload port is idle while the core runs. The stimulus loads every instruction and data word while reset is held, and only then drops reset. Programs mix a directed prefix, covering every class, a zero-register write and both branch outcomes, with seeded random instructions. Each cycle is compared against a bench model of the instruction set, and a reset pulse is injected partway through one program.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OP_ADD   = 6'h00;
    localparam logic [5:0] OP_SUB   = 6'h01;
    localparam logic [5:0] OP_AND   = 6'h02;
    localparam logic [5:0] OP_OR    = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_JUMP  = 6'h3F;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    use_imm;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic op_known(input logic [5:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR) || (op == OP_BEQ) || (op == OP_ADDI) ||
               (op == OP_LOAD) || (op == OP_STORE) || (op == OP_JUMP);
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_ADD: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
            end
            OP_SUB: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_AND: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_AND;
            end
            OP_OR: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_op    = ALU_OR;
            end
            OP_ADDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
            end
            OP_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.mem_read  = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch    = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.jump      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = a | b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && (waddr == AW'(g)))
                    q <= wdata;
            end
            assign regs[g] = q;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic              prog_to_dmem,
    input  logic [PAW-1:0]    prog_addr,
    input  logic [XLEN-1:0]   prog_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic [XLEN-1:0]   dbg_instr,
    output logic              dbg_wb_we,
    output logic [RIDX_W-1:0] dbg_wb_idx,
    output logic [XLEN-1:0]   dbg_wb_data
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0]   instr, imm_x, rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
    logic [5:0]        opcode;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic              alu_zero, wb_we;
    ctrl_t             ctrl;

    // Fetch and field split
    assign instr  = imem[pc_q[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm_x  = sext16(instr[15:0]);

    sc_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    assign wb_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wb_we  = ctrl.reg_write && !rst && (wb_idx != '0);

    sc_regfile #(.W(XLEN), .DEPTH(NREGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_we),
        .waddr   (wb_idx),
        .wdata   (wb_data),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign alu_b = ctrl.use_imm ? imm_x : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data array: combinational read, edge write
    assign mem_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_data   = ctrl.mem_read ? mem_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (prog_we && prog_to_dmem)
            dmem[prog_addr[DAW-1:0]] <= prog_data;
        else if (!rst && ctrl.mem_write)
            dmem[alu_y[DAW+1:2]] <= rt_val;
    end

    always_ff @(posedge clk) begin
        if (prog_we && !prog_to_dmem)
            imem[prog_addr[IAW-1:0]] <= prog_data;
    end

    // Next-PC selection
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_x[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump)
            pc_next = jmp_target;
        else if (ctrl.branch && alu_zero)
            pc_next = br_target;
        else
            pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    assign dbg_pc      = pc_q;
    assign dbg_instr   = instr;
    assign dbg_wb_we   = wb_we;
    assign dbg_wb_idx  = wb_idx;
    assign dbg_wb_data = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   dbg_pc,
    input logic [XLEN-1:0]   dbg_instr,
    input logic              dbg_wb_we,
    input logic [RIDX_W-1:0] dbg_wb_idx
);
    logic [5:0]      op;
    logic [XLEN-1:0] seq_pc, far_pc;

    assign op     = dbg_instr[31:26];
    assign seq_pc = dbg_pc + XLEN'(4);
    assign far_pc = {seq_pc[31:28], dbg_instr[25:0], 2'b00};

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BEQ && op != OP_JUMP) |=> (dbg_pc == $past(seq_pc)));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JUMP) |=> (dbg_pc == $past(far_pc)));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_wb_we |-> (dbg_wb_idx != '0));

    // R9
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_known(op) |-> !dbg_wb_we);

    // R10
    no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STORE || op == OP_BEQ || op == OP_JUMP) |-> !dbg_wb_we);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_pc     (dbg_pc),
    .dbg_instr  (dbg_instr),
    .dbg_wb_we  (dbg_wb_we),
    .dbg_wb_idx (dbg_wb_idx)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    import sc_core_pkg::*;

    localparam int IW = 64;
    localparam int DW = 64;
    localparam int AW = 6;
    localparam int RUN_CYCLES = 300;
    localparam int PROGRAMS   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prog_we = 1'b0;
    logic              prog_to_dmem = 1'b0;
    logic [AW-1:0]     prog_addr = '0;
    logic [31:0]       prog_data = '0;
    logic [31:0]       dbg_pc, dbg_instr, dbg_wb_data;
    logic              dbg_wb_we;
    logic [4:0]        dbg_wb_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .prog_we      (prog_we),
        .prog_to_dmem (prog_to_dmem),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .dbg_pc       (dbg_pc),
        .dbg_instr    (dbg_instr),
        .dbg_wb_we    (dbg_wb_we),
        .dbg_wb_idx   (dbg_wb_idx),
        .dbg_wb_data  (dbg_wb_data)
    );

    // Reference state
    logic [31:0] m_imem [IW];
    logic [31:0] m_dmem [DW];
    logic [31:0] m_rf   [32];
    logic [31:0] m_pc;
    logic        e_we;
    logic [4:0]  e_idx;
    logic [31:0] e_data, e_pc_next;
    logic        e_st;
    logic [31:0] e_st_val;
    logic [5:0]  e_st_idx;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR: return "R3";
            OP_ADDI:           return "R4";
            OP_LOAD, OP_STORE: return "R6";
            OP_BEQ:            return "R7";
            OP_JUMP:           return "R8";
            default:           return "R9";
        endcase
    endfunction

    function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt,
                                        input int rd, input logic [15:0] imm);
        if (op == OP_ADD || op == OP_SUB || op == OP_AND || op == OP_OR)
            return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Model of one instruction from the requirements
    task automatic model_eval();
        logic [31:0] ins, a, b, imm, addr, pc4;
        logic [5:0]  op;
        ins = m_imem[m_pc[AW+1:2]];
        op  = ins[31:26];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        imm = {{16{ins[15]}}, ins[15:0]};
        pc4 = m_pc + 32'd4;
        addr = a + imm;
        e_we = 1'b0; e_idx = ins[20:16]; e_data = 32'd0; e_st = 1'b0;
        e_st_val = b; e_st_idx = addr[AW+1:2];
        e_pc_next = pc4;
        case (op)
            OP_ADD: begin e_we = 1'b1; e_idx = ins[15:11]; e_data = a + b; end
            OP_SUB: begin e_we = 1'b1; e_idx = ins[15:11]; e_data = a - b; end
            OP_AND: begin e_we = 1'b1; e_idx = ins[15:11]; e_data = a & b; end
            OP_OR:  begin e_we = 1'b1; e_idx = ins[15:11]; e_data = a | b; end
            OP_ADDI: begin e_we = 1'b1; e_data = addr; end
            OP_LOAD: begin e_we = 1'b1; e_data = m_dmem[addr[AW+1:2]]; end
            OP_STORE: e_st = 1'b1;
            OP_BEQ: if (a == b) e_pc_next = pc4 + {imm[29:0], 2'b00};
            OP_JUMP: e_pc_next = {pc4[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        if (e_idx == 5'd0) e_we = 1'b0;
    endtask

    task automatic model_commit();
        if (e_we) m_rf[e_idx] = e_data;
        if (e_st) m_dmem[e_st_idx] = e_st_val;
        m_pc = e_pc_next;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        m_pc = 32'd0;
    endtask

    task automatic compare_cycle();
        string t;
        model_eval();
        t = tag_of(m_imem[m_pc[AW+1:2]][31:26]);
        check(dbg_pc == m_pc, "R2 pc", dbg_pc, m_pc);
        check(dbg_instr == m_imem[m_pc[AW+1:2]], "R2 fetch", dbg_instr, m_imem[m_pc[AW+1:2]]);
        if (m_imem[m_pc[AW+1:2]][20:16] == 5'd0 || m_imem[m_pc[AW+1:2]][15:11] == 5'd0)
            check(dbg_wb_we == e_we, "R5 wb enable", 32'(dbg_wb_we), 32'(e_we));
        else if (e_st)
            check(dbg_wb_we == 1'b0, "R10 wb enable", 32'(dbg_wb_we), 32'd0);
        else
            check(dbg_wb_we == e_we, {t, " wb enable"}, 32'(dbg_wb_we), 32'(e_we));
        if (e_we) begin
            check(dbg_wb_idx == e_idx, {t, " wb index"}, 32'(dbg_wb_idx), 32'(e_idx));
            check(dbg_wb_data == e_data, {t, " wb data"}, dbg_wb_data, e_data);
        end
        model_commit();
    endtask

    task automatic load_all();
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_to_dmem = 1'b0; prog_addr = AW'(i); prog_data = m_imem[i];
        end
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_to_dmem = 1'b1; prog_addr = AW'(i); prog_data = m_dmem[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    function automatic logic [31:0] rand_instr();
        logic [5:0] ops [10] = '{OP_ADD, OP_SUB, OP_AND, OP_OR, OP_ADDI, OP_LOAD,
                                 OP_STORE, OP_BEQ, OP_JUMP, 6'h15};
        logic [5:0]  op;
        logic [15:0] imm;
        int rs, rt, rd;
        op = ops[$urandom % 10];
        if (op == 6'h15) op = 6'($urandom % 64);
        rs = $urandom % 8; rt = $urandom % 8; rd = $urandom % 8;
        imm = 16'($urandom);
        if (op == OP_BEQ) imm = 16'($signed($urandom % 9) - 4);
        if (op == OP_JUMP) return {op, 26'($urandom % IW)};
        if ($urandom % 4 == 0) rs = 0;
        return enc(op, rs, rt, rd, imm);
    endfunction

    task automatic build_program(input int p);
        int k = 0;
        for (int i = 0; i < DW; i++) m_dmem[i] = $urandom;
        if (p == 0) begin
            m_imem[0]  = enc(OP_ADDI, 0, 1, 0, 16'hFFFB);  // R4 negative immediate
            m_imem[1]  = enc(OP_ADDI, 0, 2, 0, 16'd7);
            m_imem[2]  = enc(OP_ADD, 1, 2, 3, 16'd0);      // R3
            m_imem[3]  = enc(OP_SUB, 1, 2, 4, 16'd0);
            m_imem[4]  = enc(OP_AND, 1, 2, 5, 16'd0);
            m_imem[5]  = enc(OP_OR, 1, 2, 6, 16'd0);
            m_imem[6]  = enc(OP_ADDI, 2, 0, 0, 16'd1);     // R5 write to register 0
            m_imem[7]  = enc(OP_STORE, 0, 1, 0, 16'd8);    // R6, R10
            m_imem[8]  = enc(OP_LOAD, 0, 7, 0, 16'd8);
            m_imem[9]  = enc(OP_BEQ, 2, 2, 0, 16'd1);      // R7 taken
            m_imem[10] = enc(OP_ADDI, 0, 8, 0, 16'd99);
            m_imem[11] = enc(OP_BEQ, 1, 2, 0, 16'd5);      // R7 not taken
            m_imem[12] = {6'h15, 26'h3FFFFFF};             // R9
            m_imem[13] = {OP_JUMP, 26'd15};                // R8
            m_imem[14] = enc(OP_ADDI, 0, 9, 0, 16'd1);
            k = 15;
        end
        for (int i = k; i < IW; i++) m_imem[i] = rand_instr();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < PROGRAMS; p++) begin
            rst = 1'b1;
            build_program(p);
            load_all();
            @(negedge clk);
            rst = 1'b0;
            model_reset();
            #1;
            // R1: reset state visible after release
            check(dbg_pc == 32'd0, "R1 pc after reset", dbg_pc, 32'd0);
            for (int c = 0; c < RUN_CYCLES; c++) begin
                if (c > 0) begin
                    @(negedge clk);
                    #1;
                end
                if (p == 2 && c == 150) begin
                    rst = 1'b1;
                    @(negedge clk);
                    @(negedge clk);
                    rst = 1'b0;
                    model_reset();
                    #1;
                    check(dbg_pc == 32'd0, "R1 pc after mid-run reset", dbg_pc, 32'd0);
                end
                compare_cycle();
            end
        end
        // R5: register 0 still reads zero through an OR with itself
        rst = 1'b1;
        for (int i = 0; i < IW; i++) m_imem[i] = enc(OP_OR, 0, 0, 10, 16'd0);
        load_all();
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(dbg_wb_data == 32'd0, "R5 zero read", dbg_wb_data, 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule